// File: doc/BRIEF.md
# One-Time-Programmable Byte Program-Verify Sequencer

This block steps through a span of byte addresses and burns each byte into a one-time-programmable array through a strobe-style interface. The interface has an active-low chip enable, an active-low output enable and an active-low program strobe, plus a flag that enables the programming high voltage. At each address the block drives the wanted byte, which comes from a data source indexed by the same address bus. It fires one program pulse of fixed length and then reads the cell back. If the read value is wrong, it fires again, up to a bounded number of pulses.

When every byte in the span reads correctly, the block drops the high-voltage flag. It then walks the whole span a second time at normal read conditions and compares each byte again. A one-cycle completion pulse reports the outcome. Two sticky flags hold the result until the next start: one for a clean pass, and one for retry exhaustion.

Top module: `pv_prog_seq`

## Requirements
- R1: After reset, chip enable, output enable and program strobe are all high (inactive), the high-voltage flag is low, and done, pass and error are low.
- R2: Each program pulse holds the program strobe low for exactly PULSE_CYC clock cycles. Throughout the pulse, chip enable is low, the high-voltage flag is high, and the address does not change.
- R3: After each pulse, the cell is read back with chip enable and output enable low and the program strobe high. The read byte is compared with the source byte, so the programming phase makes one read per pulse.
- R4: A readback mismatch at an address that has had fewer than MAX_PULSES pulses causes another pulse at the same address. No address ever receives more than MAX_PULSES pulses.
- R5: A mismatch after the MAX_PULSES-th pulse at one address ends the run at once. Done pulses, error reads 1, pass reads 0, the high-voltage flag is low, and no verify reads take place.
- R6: A readback match moves to the next address with the pulse count restarted at zero. The span covers the start address through the end address inclusive, and it does not wrap when the end address is the top of the address space.
- R7: The high-voltage flag is low while idle. It is high from the first cycle after an accepted start, and it is low during every read of the verify walk.
- R8: The verify walk reads every address of the span exactly once. Any mismatch gives pass 0 with error 0; otherwise pass reads 1.
- R9: Done is high for exactly one cycle per run. Pass and error keep their values until the next accepted start, which clears both of them.
- R10: A start request is accepted only while idle. A start raised during a run has no effect on the addresses programmed or on the result.
- R11: The program strobe and the output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (sampled only while idle) |
| lo_addr_i | input | AW | First address of the span |
| hi_addr_i | input | AW | Last address of the span (not below lo_addr_i) |
| addr_o | output | AW | Address to the array and to the data source |
| src_byte_i | input | DW | Wanted byte for addr_o from the data source |
| wr_byte_o | output | DW | Byte presented to the array data pins |
| rd_byte_i | input | DW | Byte read from the array |
| ce_no | output | 1 | Chip enable, active low |
| oe_no | output | 1 | Output enable, active low |
| pgm_no | output | 1 | Program strobe, active low |
| hv_en_o | output | 1 | Programming high-voltage enable |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Run finished with a clean verify walk |
| err_o | output | 1 | Run stopped on pulse-limit exhaustion |

## Verification
The bench builds the block with an 8-bit address, a 4-cycle pulse, 2-cycle reads and the full limit of 25 pulses. The short pulse keeps every run brief, so the exact pulse width can be measured on each pulse. With the full limit kept, a byte that needs exactly 25 pulses and a byte that never settles can both be exercised. This includes a stubborn byte at the last address and a span that ends at the top address. A behavioural array model corrupts chosen cells only at read voltage, which drives the verify-fail path.

// File: rtl/pv_pkg.sv
package pv_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_PSET,
      S_PULSE,
      S_PREAD,
      S_VSET,
      S_VREAD,
      S_DONE
   } seq_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pv_timer.sv
module pv_timer #(
   parameter int unsigned TW = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (load_i)          cnt_q <= val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   generate
      if (TW < 1) begin : g_bad_tw
         $error("pv_timer: TW must be at least 1");
      end
   endgenerate

   // a running interval is never cut short by a reload
   AST_TMR_RELOAD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> zero_o); // R2

endmodule

// File: rtl/pv_addr_walk.sv
module pv_addr_walk #(
   parameter int unsigned AW = 17
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [AW-1:0] lo_i,
   input  logic [AW-1:0] hi_i,
   input  logic          rewind_i,
   input  logic          step_i,
   output logic [AW-1:0] addr_o,
   output logic          last_o
);

   logic [AW-1:0] lo_q, hi_q, addr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q   <= '0;
         hi_q   <= '0;
         addr_q <= '0;
      end else if (start_i) begin
         lo_q   <= lo_i;
         hi_q   <= hi_i;
         addr_q <= lo_i;
      end else if (rewind_i) begin
         addr_q <= lo_q;
      end else if (step_i) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   assign addr_o = addr_q;
   assign last_o = (addr_q == hi_q);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("pv_addr_walk: AW must be at least 1");
      end
   endgenerate

   AST_WALK_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_i |-> !last_o); // R6

   AST_WALK_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({start_i, rewind_i, step_i}) <= 1); // R6

endmodule

// File: rtl/pv_retry_cnt.sv
module pv_retry_cnt #(
   parameter int unsigned MAX_PULSES = 25
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_max_o
);

   localparam int unsigned RW = pv_pkg::cnt_width(MAX_PULSES);
   localparam logic [RW-1:0] LIMIT = RW'(MAX_PULSES);

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (clr_i)    cnt_q <= '0;
      else if (inc_i)    cnt_q <= cnt_q + 1'b1;
   end

   assign at_max_o = (cnt_q == LIMIT);

   generate
      if (MAX_PULSES < 1) begin : g_bad_max
         $error("pv_retry_cnt: MAX_PULSES must be at least 1");
      end
   endgenerate

   // the sequencer never asks for a pulse beyond the limit
   AST_RETRY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i |-> !at_max_o); // R4

   AST_RETRY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(inc_i && clr_i)); // R6

endmodule

// File: rtl/pv_prog_seq.sv
module pv_prog_seq
   import pv_pkg::*;
#(
   parameter int unsigned AW         = 17,
   parameter int unsigned DW         = 8,
   parameter int unsigned PULSE_CYC  = 5000,
   parameter int unsigned READ_CYC   = 2,
   parameter int unsigned MAX_PULSES = 25
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [AW-1:0] lo_addr_i,
   input  logic [AW-1:0] hi_addr_i,
   output logic [AW-1:0] addr_o,
   input  logic [DW-1:0] src_byte_i,
   output logic [DW-1:0] wr_byte_o,
   input  logic [DW-1:0] rd_byte_i,
   output logic          ce_no,
   output logic          oe_no,
   output logic          pgm_no,
   output logic          hv_en_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          err_o
);

   localparam int unsigned TMAX = (PULSE_CYC > READ_CYC) ? PULSE_CYC : READ_CYC;
   localparam int unsigned TW   = cnt_width(TMAX);
   localparam logic [TW-1:0] PULSE_LD = TW'(PULSE_CYC - 1);
   localparam logic [TW-1:0] READ_LD  = TW'(READ_CYC - 1);

   generate
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("pv_prog_seq: PULSE_CYC must be at least 1");
      end
      if (READ_CYC < 1) begin : g_bad_read
         $error("pv_prog_seq: READ_CYC must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("pv_prog_seq: DW must be at least 1");
      end
   endgenerate

   seq_state_e    st_q, st_d;
   logic          hv_q, pass_q, err_q, vfail_q;
   logic          tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic          walk_start, walk_rewind, walk_step, walk_last;
   logic          rt_clr, rt_inc, rt_max;
   logic          byte_ok;

   assign byte_ok = (rd_byte_i == src_byte_i);

   pv_timer #(.TW(TW)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   pv_addr_walk #(.AW(AW)) u_walk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (walk_start),
      .lo_i     (lo_addr_i),
      .hi_i     (hi_addr_i),
      .rewind_i (walk_rewind),
      .step_i   (walk_step),
      .addr_o   (addr_o),
      .last_o   (walk_last)
   );

   pv_retry_cnt #(.MAX_PULSES(MAX_PULSES)) u_retry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (rt_clr),
      .inc_i    (rt_inc),
      .at_max_o (rt_max)
   );

   always_comb begin
      st_d        = st_q;
      tmr_load    = 1'b0;
      tmr_val     = READ_LD;
      walk_start  = 1'b0;
      walk_rewind = 1'b0;
      walk_step   = 1'b0;
      rt_clr      = 1'b0;
      rt_inc      = 1'b0;
      case (st_q)
         S_IDLE: begin
            if (start_i) begin
               st_d       = S_PSET;
               walk_start = 1'b1;
               rt_clr     = 1'b1;
            end
         end
         S_PSET: begin
            st_d     = S_PULSE;
            tmr_load = 1'b1;
            tmr_val  = PULSE_LD;
         end
         S_PULSE: begin
            if (tmr_zero) begin
               st_d     = S_PREAD;
               tmr_load = 1'b1;
               rt_inc   = 1'b1;
            end
         end
         S_PREAD: begin
            if (tmr_zero) begin
               if (byte_ok) begin
                  if (walk_last) begin
                     st_d        = S_VSET;
                     walk_rewind = 1'b1;
                  end else begin
                     st_d      = S_PSET;
                     walk_step = 1'b1;
                     rt_clr    = 1'b1;
                  end
               end else if (rt_max) begin
                  st_d = S_DONE;
               end else begin
                  st_d = S_PSET;
               end
            end
         end
         S_VSET: begin
            st_d     = S_VREAD;
            tmr_load = 1'b1;
         end
         S_VREAD: begin
            if (tmr_zero) begin
               if (walk_last) begin
                  st_d = S_DONE;
               end else begin
                  st_d      = S_VSET;
                  walk_step = 1'b1;
               end
            end
         end
         S_DONE:  st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= S_IDLE;
         hv_q    <= 1'b0;
         pass_q  <= 1'b0;
         err_q   <= 1'b0;
         vfail_q <= 1'b0;
      end else begin
         st_q <= st_d;
         case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  hv_q    <= 1'b1;
                  pass_q  <= 1'b0;
                  err_q   <= 1'b0;
                  vfail_q <= 1'b0;
               end
            end
            S_PREAD: begin
               if (tmr_zero) begin
                  if (byte_ok && walk_last) begin
                     hv_q <= 1'b0;
                  end else if (!byte_ok && rt_max) begin
                     hv_q  <= 1'b0;
                     err_q <= 1'b1;
                  end
               end
            end
            S_VREAD: begin
               if (tmr_zero) begin
                  if (!byte_ok)  vfail_q <= 1'b1;
                  if (walk_last) pass_q  <= !(vfail_q || !byte_ok);
               end
            end
            default: ;
         endcase
      end
   end

   assign ce_no     = !(st_q inside {S_PSET, S_PULSE, S_PREAD, S_VSET, S_VREAD});
   assign oe_no     = !(st_q inside {S_PREAD, S_VREAD});
   assign pgm_no    = (st_q != S_PULSE);
   assign wr_byte_o = src_byte_i;
   assign hv_en_o   = hv_q;
   assign done_o    = (st_q == S_DONE);
   assign pass_o    = pass_q;
   assign err_o     = err_q;

   AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(!pgm_no && !oe_no)); // R11

   AST_PGM_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pgm_no |-> (!ce_no && hv_en_o)); // R2

   AST_PGM_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pgm_no && $past(!pgm_no)) |-> $stable(addr_o)); // R2

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R9

   AST_RESULT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pass_o && err_o)); // R5

   AST_DONE_HV_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !hv_en_o); // R7

   AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ce_no && !done_o && !$past(done_o) && !start_i) |=> ($stable(pass_o) && $stable(err_o))); // R9

endmodule

// File: tb/pv_prog_seq_tb_top.sv
module pv_prog_seq_tb_top;

   localparam int AW  = 8;
   localparam int DW  = 8;
   localparam int PW  = 4;
   localparam int RC  = 2;
   localparam int MAXP = 25;
   localparam int NADDR = 1 << AW;

   typedef struct packed {
      logic [7:0] lo;
      logic [7:0] hi;
      logic [7:0] slow;
      logic [7:0] sneed;
      logic       fv;
      logic [7:0] faddr;
   } case_t;

   localparam int NVEC = 8;
   localparam case_t VEC [NVEC] = '{
      '{8'd0,   8'd3,   8'd200, 8'd1,  1'b0, 8'd0},
      '{8'd10,  8'd14,  8'd12,  8'd3,  1'b0, 8'd0},
      '{8'd20,  8'd22,  8'd21,  8'd25, 1'b0, 8'd0},
      '{8'd30,  8'd33,  8'd31,  8'd26, 1'b0, 8'd0},
      '{8'd40,  8'd43,  8'd200, 8'd1,  1'b1, 8'd42},
      '{8'd50,  8'd50,  8'd50,  8'd2,  1'b0, 8'd0},
      '{8'd250, 8'd255, 8'd200, 8'd1,  1'b0, 8'd0},
      '{8'd60,  8'd62,  8'd62,  8'd26, 1'b0, 8'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] lo_addr = '0, hi_addr = '0;
   logic [AW-1:0] addr;
   logic [DW-1:0] src_byte, wr_byte, rd_byte;
   logic ce_n, oe_n, pgm_n, hv_en, done, pass, err;

   always #10 clk = ~clk;

   pv_prog_seq #(.AW(AW), .DW(DW), .PULSE_CYC(PW), .READ_CYC(RC), .MAX_PULSES(MAXP)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .lo_addr_i(lo_addr), .hi_addr_i(hi_addr), .addr_o(addr),
      .src_byte_i(src_byte), .wr_byte_o(wr_byte), .rd_byte_i(rd_byte),
      .ce_no(ce_n), .oe_no(oe_n), .pgm_no(pgm_n), .hv_en_o(hv_en),
      .done_o(done), .pass_o(pass), .err_o(err)
   );

   // array model
   int         need [NADDR];
   logic [7:0] flip [NADDR];
   int         pcnt [NADDR];
   logic [7:0] lat  [NADDR];
   bit         clr_req = 1'b0;

   assign src_byte = addr ^ 8'hA5;
   assign rd_byte  = (!ce_n && !oe_n)
                   ? (((pcnt[addr] >= need[addr]) ? lat[addr] : ~lat[addr]) ^ (hv_en ? 8'h00 : flip[addr]))
                   : 8'h00;

   // monitor
   int   m_pulses, m_preads, m_vreads, m_maxp, m_wbad, m_qbad, m_xbad, plen;
   logic pgm_prev = 1'b1, oe_prev = 1'b1;
   logic [AW-1:0] paddr;

   always @(posedge clk) begin
      if (clr_req) begin
         for (int i = 0; i < NADDR; i++) begin
            pcnt[i] = 0;
            lat[i]  = 8'hFF;
         end
         m_pulses = 0; m_preads = 0; m_vreads = 0; m_maxp = 0;
         m_wbad = 0; m_qbad = 0; m_xbad = 0; plen = 0;
      end else if (rst_n) begin
         if (!pgm_n && !oe_n) m_xbad++;
         if (!pgm_n) begin
            if (pgm_prev) begin
               plen = 1;
               paddr = addr;
               pcnt[addr]++;
               lat[addr] = wr_byte;
               m_pulses++;
               if (pcnt[addr] > m_maxp) m_maxp = pcnt[addr];
            end else begin
               plen++;
            end
            if (ce_n || !hv_en || addr != paddr) m_qbad++;
         end else if (!pgm_prev && plen != PW) begin
            m_wbad++;
         end
         if (!oe_n && oe_prev) begin
            if (!pgm_n || ce_n) m_xbad++;
            if (hv_en) m_preads++;
            else       m_vreads++;
         end
      end
      pgm_prev = pgm_n;
      oe_prev  = oe_n;
   end

   int total = 0;
   int bad   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic clear_model();
      for (int i = 0; i < NADDR; i++) begin
         need[i] = 1;
         flip[i] = 8'h00;
      end
      @(negedge clk) clr_req = 1'b1;
      @(negedge clk) clr_req = 1'b0;
   endtask

   int r_pass, r_err, r_hv;

   task automatic run(input int lo, input int hi, input bit ghost);
      int n;
      @(negedge clk);
      chk(hv_en == 1'b0, "R7 hv low while idle", hv_en, 0);
      lo_addr = lo[AW-1:0];
      hi_addr = hi[AW-1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(hv_en == 1'b1, "R7 hv high after start", hv_en, 1);
      chk(pass == 1'b0 && err == 1'b0, "R9 results cleared at start", {pass, err}, 0);
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
         if (ghost && n == 5) begin
            start = 1'b1; lo_addr = 8'd100; hi_addr = 8'd100;
         end else if (ghost && n == 6) begin
            start = 1'b0; lo_addr = lo[AW-1:0]; hi_addr = hi[AW-1:0];
         end
      end
      chk(done == 1'b1, "R9 done seen", done, 1);
      r_pass = pass; r_err = err; r_hv = hv_en;
      @(negedge clk);
      chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
      repeat (5) @(negedge clk);
      chk(pass == r_pass && err == r_err, "R9 results hold after done", {pass, err}, {r_pass[0], r_err[0]});
      chk(m_wbad == 0, "R2 pulse width", m_wbad, 0);
      chk(m_qbad == 0, "R2 strobes and address during pulse", m_qbad, 0);
      chk(m_xbad == 0, "R11 strobe overlap", m_xbad, 0);
      chk(m_preads == m_pulses, "R3 one readback per pulse", m_preads, m_pulses);
      chk(m_maxp <= MAXP, "R4 pulses per address bounded", m_maxp, MAXP);
   endtask

   initial begin
      int e_pulses, e_vreads, e_pass, e_err, lo, hi, sl, sn, fa;
      bit in_rng;
      clear_model();
      repeat (2) @(negedge clk);
      chk(ce_n && oe_n && pgm_n, "R1 strobes inactive in reset", {ce_n, oe_n, pgm_n}, 7);
      chk(!hv_en && !done && !pass && !err, "R1 flags low in reset", {hv_en, done, pass, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ce_n && oe_n && pgm_n && !hv_en, "R1 idle after reset", {ce_n, oe_n, pgm_n, hv_en}, 14);

      for (int v = 0; v < NVEC; v++) begin
         lo = VEC[v].lo; hi = VEC[v].hi; sl = VEC[v].slow; sn = VEC[v].sneed; fa = VEC[v].faddr;
         clear_model();
         need[sl] = sn;
         if (VEC[v].fv) flip[fa] = 8'h10;
         in_rng   = (sl >= lo) && (sl <= hi);
         e_err    = (in_rng && sn > MAXP) ? 1 : 0;
         e_pulses = e_err ? (sl - lo) + MAXP : (hi - lo + 1) + (in_rng ? sn - 1 : 0);
         e_vreads = e_err ? 0 : hi - lo + 1;
         e_pass   = (!e_err && !(VEC[v].fv && fa >= lo && fa <= hi)) ? 1 : 0;
         run(lo, hi, 1'b0);
         chk(m_pulses == e_pulses, "R4 R6 pulse total", m_pulses, e_pulses);
         chk(m_vreads == e_vreads, "R8 R5 verify reads", m_vreads, e_vreads);
         chk(r_err == e_err, "R5 error flag", r_err, e_err);
         chk(r_pass == e_pass, "R8 pass flag", r_pass, e_pass);
         chk(r_hv == 0, "R7 hv low at done", r_hv, 0);
      end

      // start raised mid-run must not disturb the run
      clear_model();
      run(70, 72, 1'b1);
      chk(m_pulses == 3, "R10 ghost start pulses", m_pulses, 3);
      chk(m_vreads == 3, "R10 ghost start verify reads", m_vreads, 3);
      chk(r_pass == 1 && r_err == 0, "R10 ghost start result", r_pass, 1);
      chk(pcnt[100] == 0, "R10 ghost address untouched", pcnt[100], 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule